// File: doc/BRIEF.md
# Shift and Bit-Manipulation Execution Unit

This unit is one slice of the execute stage of an 8-bit microcontroller datapath. Each cycle it takes an operation code, an operand and a 3-bit index. It returns a result for the general register file, a write enable for that result, and the processor status byte. The status byte is held in a clocked register inside the unit, and every operation updates it on the clock edge that ends its single execute cycle.

The unit covers five one-operand shift and rotate forms, a nibble exchange, the copy of one bit between the operand and the T flag, and forcing a single status flag to 1 or 0. The named set and clear operations for individual flags are not separate codes. A decoder maps them onto the two force codes with the matching index. Rotates take the carry bit from the status register as their fill bit, and the result of one operation feeds the next operation in the following cycle without a stall.

Status bit positions: I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0.

Top module: `sbu_core`

## Requirements
- R1: Operation codes on `op_i`: 0 idle, 1 shift left, 2 shift right, 3 rotate left, 4 rotate right, 5 arithmetic shift right, 6 nibble exchange, 7 bit store, 8 bit load, 9 flag force-one, 10 flag force-zero. Code 0 and codes 11 to 15 drive `wr_o` low and leave the status register unchanged.
- R2: Shift left returns the operand moved up one place with 0 in bit 0, and C takes the old bit 7. Shift right returns the operand moved down one place with 0 in bit 7, and C takes the old bit 0.
- R3: Rotate left puts the stored C into bit 0, and C takes the old bit 7. Rotate right puts the stored C into bit 7, and C takes the old bit 0.
- R4: Arithmetic shift right moves bits 7..1 into 6..0, keeps bit 7, and sets C from the old bit 0.
- R5: Nibble exchange swaps the upper four bits with the lower four bits and changes no status bit.
- R6: After any of codes 1 to 5: N = result bit 7, Z = 1 exactly when the result is zero, V = N xor C, S = N xor V. I, T and H keep their values.
- R7: Bit store copies operand bit `idx_i` into T and changes no other status bit.
- R8: Bit load returns the operand with bit `idx_i` replaced by the stored T and changes no status bit.
- R9: Flag force-one and force-zero set status bit `idx_i` to 1 or 0 and change no other status bit.
- R10: `wr_o` is high for codes 1 to 6 and 8, and low for codes 7, 9 and 10.
- R11: A low `rst_n` at a rising clock edge clears the status register to 0x00.
- R12: Each operation completes in one cycle. An operation issued in the cycle after another one sees the status that the earlier operation produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Operation code (see R1) |
| opnd_i | input | 8 | Operand read from the destination register |
| idx_i | input | 3 | Bit index for store and load, flag index for force operations |
| res_o | output | 8 | Result to write back |
| wr_o | output | 1 | Result write enable |
| sreg_o | output | 8 | Registered status byte |

## Verification
The bench builds the unit at its default width of 8 bits. At that width the operand space is small enough to cover completely. Every shift, rotate and nibble-exchange form is driven with all 256 operand values under both carry states. Bit load is driven with every operand, index and T value. Back-to-back rotates chain the carry through consecutive cycles, and the unused codes are driven over a status byte whose bits are mixed ones and zeros.

// File: rtl/sbu_pkg.sv
// Shared definitions for the shift and bit-manipulation unit.
// Assumes an 8-bit status byte whose flag positions are fixed below.
package sbu_pkg;
    localparam int SR_W      = 8;
    localparam int FLAG_IX_W = 3;

    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_N = 2;
    localparam int FL_V = 3;
    localparam int FL_S = 4;
    localparam int FL_H = 5;
    localparam int FL_T = 6;
    localparam int FL_I = 7;

    typedef enum logic [3:0] {
        SBU_NOP  = 4'd0,
        SBU_LSL  = 4'd1,
        SBU_LSR  = 4'd2,
        SBU_ROL  = 4'd3,
        SBU_ROR  = 4'd4,
        SBU_ASR  = 4'd5,
        SBU_SWAP = 4'd6,
        SBU_BST  = 4'd7,
        SBU_BLD  = 4'd8,
        SBU_FSET = 4'd9,
        SBU_FCLR = 4'd10
    } sbu_op_e;
endpackage

// File: rtl/sbu_shift.sv
// Shift, rotate and nibble-exchange datapath.
// Purely combinational. Assumes DATA_W is even and at least 2.
// For operations outside its class it passes the operand through and
// drives is_shift low.
module sbu_shift
    import sbu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  sbu_op_e             op,
    input  logic [DATA_W-1:0]   opnd,
    input  logic                cin,
    output logic [DATA_W-1:0]   res,
    output logic                cout,
    output logic                is_shift
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] swapped;

    // Nibble exchange: upper and lower halves trade places.
    generate
        for (genvar g = 0; g < HALF; g++) begin : g_swap
            assign swapped[g]        = opnd[g + HALF];
            assign swapped[g + HALF] = opnd[g];
        end
    endgenerate

    // Select the shifted value and the bit that leaves the operand.
    always_comb begin
        res      = opnd;
        cout     = 1'b0;
        is_shift = 1'b0;
        case (op)
            SBU_LSL: begin
                res      = {opnd[DATA_W-2:0], 1'b0};
                cout     = opnd[DATA_W-1];
                is_shift = 1'b1;
            end
            SBU_LSR: begin
                res      = {1'b0, opnd[DATA_W-1:1]};
                cout     = opnd[0];
                is_shift = 1'b1;
            end
            SBU_ROL: begin
                res      = {opnd[DATA_W-2:0], cin};
                cout     = opnd[DATA_W-1];
                is_shift = 1'b1;
            end
            SBU_ROR: begin
                res      = {cin, opnd[DATA_W-1:1]};
                cout     = opnd[0];
                is_shift = 1'b1;
            end
            SBU_ASR: begin
                res      = {opnd[DATA_W-1], opnd[DATA_W-1:1]};
                cout     = opnd[0];
                is_shift = 1'b1;
            end
            SBU_SWAP: res = swapped;
            default: ;
        endcase
    end
endmodule

// File: rtl/sbu_bitop.sv
// Single-bit transfer between the operand and the T flag.
// Combinational. ld_res is the operand with bit idx replaced by tflag.
// st_bit is operand bit idx.
module sbu_bitop #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] opnd,
    input  logic [IDX_W-1:0]  idx,
    input  logic              tflag,
    output logic [DATA_W-1:0] ld_res,
    output logic              st_bit
);
    // Build the bit-load result and pick the bit to store.
    always_comb begin
        ld_res      = opnd;
        ld_res[idx] = tflag;
        st_bit      = opnd[idx];
    end
endmodule

// File: rtl/sbu_flags.sv
// Next-state logic for the status byte.
// Combinational. Shift-class results rewrite C, Z, N, V and S.
// Bit store rewrites T. Force operations write one indexed bit.
// Every other bit holds its value.
module sbu_flags
    import sbu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  sbu_op_e               op,
    input  logic [SR_W-1:0]       sreg_q,
    input  logic [DATA_W-1:0]     res,
    input  logic                  cout,
    input  logic                  is_shift,
    input  logic                  st_bit,
    input  logic [FLAG_IX_W-1:0]  fidx,
    output logic [SR_W-1:0]       sreg_d
);
    logic n_f;
    logic v_f;

    // Negative and overflow terms shared by the shift class.
    always_comb begin
        n_f = res[DATA_W-1];
        v_f = n_f ^ cout;
    end

    // Merge the per-operation flag writes over the held status.
    always_comb begin
        sreg_d = sreg_q;
        if (is_shift) begin
            sreg_d[FL_C] = cout;
            sreg_d[FL_Z] = (res == '0);
            sreg_d[FL_N] = n_f;
            sreg_d[FL_V] = v_f;
            sreg_d[FL_S] = n_f ^ v_f;
        end
        case (op)
            SBU_BST:  sreg_d[FL_T] = st_bit;
            SBU_FSET: sreg_d[fidx] = 1'b1;
            SBU_FCLR: sreg_d[fidx] = 1'b0;
            default: ;
        endcase
    end
endmodule

// File: rtl/sbu_core.sv
// Top of the shift and bit-manipulation unit.
// The result and the write enable are combinational from the inputs and the
// held status. The status byte is registered and cleared by a synchronous
// active-low reset. Assumes DATA_W >= 8 so that idx_i can also address
// the status byte.
module sbu_core
    import sbu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [DATA_W-1:0] res_o,
    output logic              wr_o,
    output logic [SR_W-1:0]   sreg_o
);
    sbu_op_e           op;
    logic [SR_W-1:0]   sreg_q;
    logic [SR_W-1:0]   sreg_d;
    logic [DATA_W-1:0] sh_res;
    logic [DATA_W-1:0] ld_res;
    logic              sh_cout;
    logic              is_shift;
    logic              st_bit;

    assign op = sbu_op_e'(op_i);

    sbu_shift #(.DATA_W(DATA_W)) u_shift (
        .op       (op),
        .opnd     (opnd_i),
        .cin      (sreg_q[FL_C]),
        .res      (sh_res),
        .cout     (sh_cout),
        .is_shift (is_shift)
    );

    sbu_bitop #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bitop (
        .opnd   (opnd_i),
        .idx    (idx_i),
        .tflag  (sreg_q[FL_T]),
        .ld_res (ld_res),
        .st_bit (st_bit)
    );

    sbu_flags #(.DATA_W(DATA_W)) u_flags (
        .op       (op),
        .sreg_q   (sreg_q),
        .res      (sh_res),
        .cout     (sh_cout),
        .is_shift (is_shift),
        .st_bit   (st_bit),
        .fidx     (idx_i[FLAG_IX_W-1:0]),
        .sreg_d   (sreg_d)
    );

    // Choose the write-back value and decide whether it is written.
    always_comb begin
        res_o = (op == SBU_BLD) ? ld_res : sh_res;
        case (op)
            SBU_LSL, SBU_LSR, SBU_ROL, SBU_ROR,
            SBU_ASR, SBU_SWAP, SBU_BLD: wr_o = 1'b1;
            default:                    wr_o = 1'b0;
        endcase
    end

    // Hold the status byte between operations.
    always_ff @(posedge clk) begin
        if (!rst_n) sreg_q <= '0;
        else        sreg_q <= sreg_d;
    end

    assign sreg_o = sreg_q;
endmodule

// File: rtl/sbu_chk.sv
// Property checker for sbu_core, attached by the bind below.
// Observes ports only.
module sbu_chk
    import sbu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] opnd_i,
    input logic [IDX_W-1:0]  idx_i,
    input logic [DATA_W-1:0] res_o,
    input logic              wr_o,
    input logic [SR_W-1:0]   sreg_o
);
    localparam logic [SR_W-1:0] T_MASK = SR_W'(1) << FL_T;
    localparam logic [SR_W-1:0] ITH_MASK =
        (SR_W'(1) << FL_I) | (SR_W'(1) << FL_T) | (SR_W'(1) << FL_H);

    logic shift_op;
    assign shift_op = (op_i >= 4'd1) && (op_i <= 4'd5);

    a_r1_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd0 || op_i > 4'd10) |=> $stable(sreg_o));
    a_r1_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd0 || op_i > 4'd10) |-> !wr_o);
    a_r2_lsl_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == SBU_LSL) |=> sreg_o[FL_C] == $past(opnd_i[DATA_W-1]));
    a_r2_lsr_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == SBU_LSR) |=> sreg_o[FL_C] == $past(opnd_i[0]));
    a_r3_rol_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == SBU_ROL) |-> res_o[0] == sreg_o[FL_C]);
    a_r3_ror_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == SBU_ROR) |-> res_o[DATA_W-1] == sreg_o[FL_C]);
    a_r4_asr_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == SBU_ASR) |-> res_o[DATA_W-1] == opnd_i[DATA_W-1]);
    a_r5_swap_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == SBU_SWAP) |=> $stable(sreg_o));
    a_r6_zero_neg: assert property (@(posedge clk) disable iff (!rst_n)
        shift_op |=> (sreg_o[FL_Z] == ($past(res_o) == '0)) &&
                     (sreg_o[FL_N] == $past(res_o[DATA_W-1])));
    a_r6_ovf_sign: assert property (@(posedge clk) disable iff (!rst_n)
        shift_op |=> (sreg_o[FL_V] == (sreg_o[FL_N] ^ sreg_o[FL_C])) &&
                     (sreg_o[FL_S] == (sreg_o[FL_N] ^ sreg_o[FL_V])));
    a_r6_keep_ith: assert property (@(posedge clk) disable iff (!rst_n)
        shift_op |=> (sreg_o & ITH_MASK) == ($past(sreg_o) & ITH_MASK));
    a_r7_store_t: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == SBU_BST) |=> (sreg_o[FL_T] == $past(opnd_i[idx_i])) &&
            ((sreg_o & ~T_MASK) == ($past(sreg_o) & ~T_MASK)));
    a_r8_load_t: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == SBU_BLD) |-> (res_o[idx_i] == sreg_o[FL_T]) && wr_o);
    a_r8_load_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == SBU_BLD) |=> $stable(sreg_o));
    a_r9_force_one: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == SBU_FSET) |=> sreg_o[$past(idx_i[FLAG_IX_W-1:0])] == 1'b1);
    a_r9_force_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == SBU_FCLR) |=> sreg_o[$past(idx_i[FLAG_IX_W-1:0])] == 1'b0);
    a_r10_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == SBU_BST || op_i == SBU_FSET || op_i == SBU_FCLR) |-> !wr_o);
    a_r11_reset_clear: assert property (@(posedge clk)
        !rst_n |=> sreg_o == '0);
endmodule

bind sbu_core sbu_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_sbu_core.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver checks the combinational result in the same
// cycle and queues the expected status byte. A monitor compares that status
// after the clock edge.
module sim_sbu_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic [7:0] opnd_i = 8'h00;
    logic [2:0] idx_i = 3'd0;
    logic [7:0] res_o;
    logic       wr_o;
    logic [7:0] sreg_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] msr = 8'h00;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    sbu_core u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .opnd_i(opnd_i),
        .idx_i(idx_i), .res_o(res_o), .wr_o(wr_o), .sreg_o(sreg_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd1, 4'd2: return "R2";
            4'd3, 4'd4: return "R3";
            4'd5:       return "R4";
            4'd6:       return "R5";
            4'd7:       return "R7";
            4'd8:       return "R8";
            4'd9, 4'd10: return "R9";
            default:    return "R1";
        endcase
    endfunction

    // Drive one operation, check the result and queue the expected status.
    task automatic do_op(input logic [3:0] op, input logic [7:0] a,
                         input logic [2:0] ix, input string tag);
        logic [7:0] er, es;
        logic ew, c, sh;
        string rt, st, wt;
        @(negedge clk);
        op_i = op; opnd_i = a; idx_i = ix;
        er = a; es = msr; ew = 1'b0; c = 1'b0; sh = 1'b0;
        case (op)
            4'd1: begin er = {a[6:0], 1'b0};   c = a[7]; sh = 1'b1; ew = 1'b1; end
            4'd2: begin er = {1'b0, a[7:1]};   c = a[0]; sh = 1'b1; ew = 1'b1; end
            4'd3: begin er = {a[6:0], msr[0]}; c = a[7]; sh = 1'b1; ew = 1'b1; end
            4'd4: begin er = {msr[0], a[7:1]}; c = a[0]; sh = 1'b1; ew = 1'b1; end
            4'd5: begin er = {a[7], a[7:1]};   c = a[0]; sh = 1'b1; ew = 1'b1; end
            4'd6: begin er = {a[3:0], a[7:4]}; ew = 1'b1; end
            4'd7: es[6] = a[ix];
            4'd8: begin er[ix] = msr[6]; ew = 1'b1; end
            4'd9:  es[ix] = 1'b1;
            4'd10: es[ix] = 1'b0;
            default: ;
        endcase
        if (sh) begin
            es[0] = c;
            es[1] = (er == 8'h00);
            es[2] = er[7];
            es[3] = er[7] ^ c;
            es[4] = er[7] ^ (er[7] ^ c);
        end
        rt = (tag != "") ? tag : req_of(op);
        st = (tag != "") ? tag : (sh ? "R6" : req_of(op));
        wt = (op == 4'd0 || op > 4'd10) ? "R1" : "R10";
        #1;
        chk(wr_o === ew, wt, "write enable", {7'd0, wr_o}, {7'd0, ew});
        if (ew) chk(res_o === er, rt, "result", res_o, er);
        exp_q.push_back(es);
        tag_q.push_back(st);
        msr = es;
    endtask

    // Monitor: compare the registered status after each rising edge.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(sreg_o === e, t, "status", sreg_o, e);
        end
    end

    task automatic set_carry(input logic cv);
        do_op(cv ? 4'd9 : 4'd10, 8'h00, 3'd0, "R9");
    endtask

    task automatic apply_reset();
        do_op(4'd0, 8'h00, 3'd0, "R1");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        chk(sreg_o === 8'h00, "R11", "status after reset", sreg_o, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        msr = 8'h00;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL R12 watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk(sreg_o === 8'h00, "R11", "status in reset", sreg_o, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // Every shift-class code, all operands, both carry states (R2-R6).
        for (int cv = 0; cv < 2; cv++)
            for (int v = 0; v < 256; v++)
                for (int op = 1; op <= 6; op++) begin
                    set_carry(cv[0]);
                    do_op(op[3:0], v[7:0], 3'd0, "");
                end

        // Bit load: every T value, operand and index (R8).
        for (int t = 0; t < 2; t++) begin
            do_op(t[0] ? 4'd9 : 4'd10, 8'h00, 3'd6, "R9");
            for (int v = 0; v < 256; v++)
                for (int ix = 0; ix < 8; ix++)
                    do_op(4'd8, v[7:0], ix[2:0], "");
        end

        // Bit store over mixed operands and all indices (R7).
        for (int k = 0; k < 4; k++)
            for (int ix = 0; ix < 8; ix++)
                do_op(4'd7, (k == 0) ? 8'hA5 : (k == 1) ? 8'h5A :
                            (k == 2) ? 8'h00 : 8'hFF, ix[2:0], "");

        // Force every flag to one and then to zero (R9).
        for (int ix = 0; ix < 8; ix++) do_op(4'd9, 8'h3C, ix[2:0], "");
        for (int ix = 0; ix < 8; ix++) do_op(4'd10, 8'hC3, ix[2:0], "");

        // Idle and unused codes over a mixed status byte (R1).
        do_op(4'd9, 8'h00, 3'd7, "R9");
        do_op(4'd9, 8'h00, 3'd4, "R9");
        do_op(4'd9, 8'h00, 3'd1, "R9");
        do_op(4'd9, 8'h00, 3'd0, "R9");
        for (int op = 11; op < 16; op++) do_op(op[3:0], 8'hFF, 3'd5, "");
        do_op(4'd0, 8'h81, 3'd2, "");

        // Back-to-back rotates chain the carry cycle by cycle (R12).
        set_carry(1'b1);
        for (int k = 0; k < 9; k++) do_op(4'd3, 8'h80 >> k, 3'd0, "R12");
        for (int k = 0; k < 9; k++) do_op(4'd4, 8'h01 << k, 3'd0, "R12");

        // Reset from a full status byte (R11).
        for (int ix = 0; ix < 8; ix++) do_op(4'd9, 8'h00, ix[2:0], "R9");
        apply_reset();

        do_op(4'd0, 8'h00, 3'd0, "R1");
        repeat (3) @(posedge clk);
        #3;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule